// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Index Register

This block merges a set of peripheral interrupt request lines into one request for a CPU interrupt controller. Each source owns a latched pending bit that is set by a rising edge on its request line. The block has no enable control: every source is always enabled. The masked view of the pending bits therefore always equals the raw view.

Software services the group through a small register port. The usual path is a single read of the index register. That read returns a code for the highest-priority pending source and, in the same access, retires that source's pending bit. The handler can branch on the code. It can then return and re-enter while the group request stays high. Software that wants its own ordering can instead read the raw or masked pending registers, which have no side effects.

Top module: `irq_grp_agg`

## Requirements
- R1: After reset all pending bits are clear, `irq_o` is low and `rdata_o` is zero.
- R2: A low-to-high transition of `req_i[n]`, seen at a clock edge, sets pending bit n at that edge. The bit stays set after the line drops. A line held high does not set the bit again once it has been cleared.
- R3: A read at address 0 returns the raw pending bits, with bit n for source n and zeros above bit N_SRC-1, and changes no state.
- R4: A read at address 1 returns the masked pending bits, which always equal the raw pending bits.
- R5: A read at address 2 returns the enable mask as ones in bits N_SRC-1..0 and zeros above, whatever has been written.
- R6: A read at address 3 returns 0 when no source is pending.
- R7: A read at address 3 returns n+1 for the lowest-numbered pending source n. Source 0 has the highest priority.
- R8: A read at address 3 clears the pending bit of exactly the reported source and leaves every other bit unchanged.
- R9: `irq_o` is high exactly while any masked pending bit is set. It stays or comes back high after a clear if another source remains pending.
- R10: If source n rises at the same edge as an index read that clears source n, the bit stays set.
- R11: `rdata_o` is loaded at the clock edge that samples `rd_i` and holds its value until the next read.
- R12: A write strobe at any address changes neither the pending bits, the enable mask nor `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Peripheral interrupt request lines |
| addr_i | input | 2 | Register word address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe (ignored) |
| wdata_i | input | DATA_W | Write data (ignored) |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined group interrupt request |

## Verification
The bench latches every one of the 256 patterns of eight sources and drains each pattern through repeated index reads. A priority encoder that favours the wrong end would produce a wrong code order. A clear that touches more than one bit would skip codes. A missing n+1 offset would make source 0 look like "nothing pending". The bench also targets the collision of a fresh edge with the clear of the same source, which a clear-wins design would lose. A source whose line stays high is cleared, which a level-sensitive design would re-set at once. Finally, writes to every address must leave both the mask and the pending state untouched.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RAW  = 2'd0,
        SEL_PEND = 2'd1,
        SEL_ENA  = 2'd2,
        SEL_IDX  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_grp_capture.sv
module irq_grp_capture #(
    parameter int unsigned N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);
    typedef struct packed {
        logic [N-1:0] req;
        logic [N-1:0] stat;
    } cap_t;

    cap_t         s_d, s_q;
    logic [N-1:0] rise;

    always_comb begin
        s_d      = s_q;
        rise     = req_i & ~s_q.req;
        s_d.req  = req_i;
        // a new edge wins over a clear of the same bit
        s_d.stat = (s_q.stat & ~clr_i) | rise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign stat_o = s_q.stat;

    // R2, R10: an observed rising edge always leaves its bit set
    assert_edge_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((stat_o & $past(req_i & ~s_q.req)) == $past(req_i & ~s_q.req)));

    // R8: only the bit named by the clear vector may fall
    assert_only_named_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(stat_o) & ~stat_o & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irq_grp_prio.sv
module irq_grp_prio #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 4
) (
    input  logic [N-1:0]     pend_i,
    output logic [IDX_W-1:0] code_o,
    output logic [N-1:0]     grant_o
);
    always_comb begin
        code_o  = '0;
        grant_o = '0;
        // scan downward so that the lowest pending number is the last assignment
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                code_o  = IDX_W'(i + 1);
                grant_o = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/irq_grp_regs.sv
module irq_grp_regs
    import irq_grp_pkg::*;
#(
    parameter int unsigned N      = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      raw_i,
    input  logic [N-1:0]      pend_i,
    input  logic [N-1:0]      ena_i,
    input  logic [IDX_W-1:0]  code_i,
    input  logic [N-1:0]      grant_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N-1:0]      clr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t      r_d, r_q;
    reg_sel_e sel;

    always_comb begin
        r_d   = r_q;
        sel   = reg_sel_e'(addr_i);
        clr_o = '0;
        if (rd_i) begin
            unique case (sel)
                SEL_RAW:  r_d.rdata = DATA_W'(raw_i);
                SEL_PEND: r_d.rdata = DATA_W'(pend_i);
                SEL_ENA:  r_d.rdata = DATA_W'(ena_i);
                SEL_IDX: begin
                    r_d.rdata = DATA_W'(code_i);
                    clr_o     = grant_i;
                end
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign rdata_o = r_q.rdata;

    assert_mask_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == SEL_ENA) |=> (rdata_o == DATA_W'({N{1'b1}})));

    assert_idx_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == SEL_IDX && raw_i == '0) |=> (rdata_o == '0));

    assert_idx_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == SEL_IDX && raw_i != '0) |=> (rdata_o != '0));

    assert_masked_equals_raw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == SEL_PEND) |=> (rdata_o == DATA_W'($past(raw_i))));

    assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/irq_grp_agg.sv
module irq_grp_agg
    import irq_grp_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_SRC-1:0]  req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int unsigned IDX_W = $clog2(N_SRC + 1);
    localparam logic [N_SRC-1:0] ENA_MASK = {N_SRC{1'b1}};

    logic [N_SRC-1:0] raw, pend, grant, clr;
    logic [IDX_W-1:0] code;

    irq_grp_capture #(.N(N_SRC)) u_cap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_i),
        .clr_i  (clr),
        .stat_o (raw)
    );

    assign pend  = raw & ENA_MASK;
    assign irq_o = |pend;

    irq_grp_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
        .pend_i  (pend),
        .code_o  (code),
        .grant_o (grant)
    );

    irq_grp_regs #(.N(N_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_i    (rd_i),
        .addr_i  (addr_i),
        .raw_i   (raw),
        .pend_i  (pend),
        .ena_i   (ENA_MASK),
        .code_i  (code),
        .grant_i (grant),
        .rdata_o (rdata_o),
        .clr_o   (clr)
    );

    // R12: a write alone never disturbs the read data
    assert_write_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !rd_i && wdata_i != '0) |=> $stable(rdata_o));

    // R9: request stays high while something remains pending after a clear
    assert_irq_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(raw & ~clr) != '0) |-> irq_o);
endmodule

// File: tb/sim_irq_grp_agg.sv
module sim_irq_grp_agg;
    localparam int N = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [1:0]    addr = '0;
    logic          rd = 1'b0, wr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_grp_agg #(.N_SRC(N), .DATA_W(DW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
        .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [DW-1:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic pulse(input logic [N-1:0] p);
        @(negedge clk); req = p;
        @(negedge clk); req = '0;
    endtask

    function automatic logic [DW-1:0] lowest_code(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return DW'(i + 1);
        return '0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, hold;
        logic [N-1:0]  m;
        repeat (3) @(negedge clk);
        chk("R1 rdata at reset", rdata, '0);
        chk("R1 irq at reset", DW'(irq), '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg(2'd3, v); chk("R6 idle index", v, '0);
        rd_reg(2'd2, v); chk("R5 mask", v, DW'({N{1'b1}}));

        // sweep every pattern of the sources, then drain it by index reads
        for (int p = 0; p < (1 << N); p++) begin
            m = N'(p);
            pulse(m);
            chk("R9 irq after set", DW'(irq), DW'(m != '0));
            rd_reg(2'd0, v); chk("R2 R3 raw", v, DW'(m));
            rd_reg(2'd1, v); chk("R4 masked", v, DW'(m));
            rd_reg(2'd0, v); chk("R3 raw read has no side effect", v, DW'(m));
            for (int k = 0; k <= N; k++) begin
                logic [DW-1:0] e;
                e = lowest_code(m);
                rd_reg(2'd3, v); chk("R7 R6 index code", v, e);
                if (e != '0) m[e-1] = 1'b0;
                chk("R9 irq after clear", DW'(irq), DW'(m != '0));
                rd_reg(2'd0, v); chk("R8 remaining bits", v, DW'(m));
                if (e == '0) break;
            end
        end

        // R10: new edge on source 2 coincides with the clear of source 2
        pulse(N'(8'b0000_0100));
        @(negedge clk); addr = 2'd3; rd = 1'b1; req = N'(8'b0000_0100);
        @(negedge clk); rd = 1'b0; req = '0; v = rdata;
        chk("R10 code of colliding source", v, DW'(3));
        rd_reg(2'd0, v); chk("R10 set wins over clear", v, DW'(8'b0000_0100));
        rd_reg(2'd3, v); chk("R10 drain", v, DW'(3));

        // R2: line held high is cleared once and does not re-set
        @(negedge clk); req = N'(1);
        @(negedge clk);
        rd_reg(2'd3, v); chk("R2 held source code", v, DW'(1));
        repeat (3) @(negedge clk);
        rd_reg(2'd0, v); chk("R2 held level no re-set", v, '0);
        chk("R9 irq low when empty", DW'(irq), '0);
        @(negedge clk); req = '0;
        @(negedge clk);

        // R12: writes to every address with all ones
        pulse(N'(8'b1010_0000));
        rd_reg(2'd1, hold);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); addr = 2'(a); wr = 1'b1; wdata = '1;
            @(negedge clk); wr = 1'b0; wdata = '0;
            chk("R12 rdata untouched by write", rdata, hold);
        end
        rd_reg(2'd0, v); chk("R12 raw untouched by write", v, DW'(8'b1010_0000));
        rd_reg(2'd2, v); chk("R5 R12 mask after writes", v, DW'({N{1'b1}}));

        // R11: data holds between reads
        hold = rdata;
        repeat (5) @(negedge clk);
        chk("R11 rdata holds", rdata, hold);
        rd_reg(2'd3, v); chk("R7 code of source 5", v, DW'(6));
        rd_reg(2'd3, v); chk("R7 code of source 7", v, DW'(8));
        rd_reg(2'd3, v); chk("R6 empty after drain", v, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule